// File: doc/BRIEF.md
# SMBus Register-Pointer Slave

This block is a slave on a two-wire SMBus/I2C-style bus that gives a host access to a bank of 8-bit registers. The registers themselves live outside the block. The block samples the clock and data lines on the fast system clock and drives the data line as open-drain. It recognises start, repeated-start and stop conditions, answers one fixed 7-bit device address, and keeps a persistent register pointer.

A write transaction loads its first data byte into the pointer (send byte). An optional second byte is written to the register the pointer selects (write byte). A read transaction returns the register at the current pointer (receive byte). Because the pointer survives a stop, a host can read the same register again and again without re-addressing it. The register file sees a plain port: the address is the pointer, and there is a one-cycle write strobe with its data, plus a read-data input.

The controller has these states:

| State | Role |
|---|---|
| ST_IDLE | Waits for a start. |
| ST_ADDR | Shifts in the address byte. |
| ST_ADDR_ACK | Acknowledges a matching address. |
| ST_PTR | Shifts in the pointer byte. |
| ST_PTR_ACK | Acknowledges the pointer byte. |
| ST_DATA | Shifts in the data byte. |
| ST_DATA_ACK | Acknowledges the data byte. |
| ST_XTRA | Shifts in surplus write bytes. |
| ST_XTRA_NAK | Leaves each surplus byte unacknowledged. |
| ST_TX | Shifts out the read byte. |
| ST_TX_ACK | Samples the host's acknowledge. |
| ST_IGNORE | Keeps the data line released until the next start or stop. |

The transitions are:

- Any state goes to ST_IDLE on a stop, and to ST_ADDR on a start.
- ST_ADDR goes to ST_ADDR_ACK when the address matches, or to ST_IGNORE when it does not.
- ST_ADDR_ACK goes to ST_TX for a read, or to ST_PTR for a write.
- ST_PTR goes to ST_PTR_ACK, then to ST_DATA, then to ST_DATA_ACK, then to ST_XTRA.
- ST_XTRA goes to ST_XTRA_NAK, and ST_XTRA_NAK goes back to ST_XTRA.
- ST_TX goes to ST_TX_ACK.
- ST_TX_ACK goes to ST_TX when the host acknowledged, or to ST_IGNORE when it did not.

All byte-state moves happen on a detected SCL falling edge once eight bits have been counted. Ack-state moves happen on the next falling edge.

Top module: `smb_ptr_slave`

## Requirements
- R1: After reset the data line is released (sda_oe low), the pointer (reg_addr) is 0x00 and reg_we is low.
- R2: An address byte of 0x5C (7-bit address 0x2E, write) or 0x5D (read), sent MSB first with the direction in bit 0, is acknowledged by holding SDA low during the ninth SCL pulse. Any other address byte is not acknowledged, and SDA stays released for all later bytes until the next start or stop.
- R3: In a write, the first byte after the address is acknowledged and loaded into the pointer, which reg_addr shows.
- R4: A second write byte is acknowledged and produces a write strobe with reg_addr equal to the pointer and reg_wdata equal to the byte.
- R5: A read sends reg_rdata at the current pointer MSB first, changing SDA only while SCL is low, and leaves the pointer unchanged.
- R6: Write bytes beyond the second are not acknowledged and change neither the pointer nor any register.
- R7: A repeated start with no stop before it restarts the address phase, so a pointer write can be followed directly by a read.
- R8: The pointer keeps its value across a stop condition.
- R9: If the host acknowledges a read byte, the same register is sent again with no increment. If the host does not acknowledge, the slave releases SDA until the next start or stop.
- R10: reg_we is high for exactly one system clock per accepted data byte, and never otherwise.
- R11: A stop at any point, including inside a byte, returns the block to idle, and the partial byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High pulls the data line low (open-drain) |
| reg_addr | output | 8 | Register pointer, used as the register-file address |
| reg_wdata | output | 8 | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register-file read data at reg_addr |

## Verification
The hardest case to reach is a direction change inside one transaction. The pointer byte must be acknowledged, and then a start must arrive while the slave is already counting the first bit of a would-be data byte; the slave must drop that partial byte and decode a read address. The bench drives this through its bit-level bus tasks: it sends the pointer byte, raises SCL once as part of the repeated start, and then checks that the returned byte comes from the new pointer. A stop placed in the middle of a byte after a pointer write is built the same way, by sending only part of a byte.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

    localparam int BYTE_W   = 8;
    localparam int LANE_SCL = 0;
    localparam int LANE_SDA = 1;
    localparam int N_LANES  = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_XTRA,
        ST_XTRA_NAK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] lvl_o,
    output logic [LANES-1:0] rise_o,
    output logic [LANES-1:0] fall_o
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [STAGES-1:0] chain;
            logic              prev;

            // Idle bus is high, so reset the chain high to avoid false edges.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                    prev  <= 1'b1;
                end else begin
                    chain <= {chain[STAGES-2:0], raw_i[g]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign lvl_o[g]  = chain[STAGES-1];
            assign rise_o[g] = chain[STAGES-1] & ~prev;
            assign fall_o[g] = ~chain[STAGES-1] & prev;
        end
    endgenerate

endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);

    // SDA may only move while SCL is low; a move while SCL is high frames a transfer.
    always_comb begin
        start_o = scl_lvl & sda_fall;
        stop_o  = scl_lvl & sda_rise;
    end

endmodule

// File: rtl/smb_byte_shift.sv
module smb_byte_shift #(
    parameter int DW = 8,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          tx_mode,
    input  logic          rise,
    input  logic          fall,
    input  logic          bit_in,
    output logic [DW-1:0] data_o,
    output logic          full_o
);

    logic [DW-1:0] data_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '1;
            cnt_q  <= '0;
        end else if (load) begin
            data_q <= load_val;
            cnt_q  <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
        end else if (rise) begin
            if (cnt_q != CW'(DW)) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (!tx_mode) begin
                data_q <= {data_q[DW-2:0], bit_in};
            end
        end else if (fall && tx_mode) begin
            data_q <= {data_q[DW-2:0], 1'b1};
        end
    end

    assign data_o = data_q;
    assign full_o = (cnt_q == CW'(DW));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DW)); // R2

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
    import smb_ptr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2E,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);

    logic [N_LANES-1:0] lvl, rise, fall;
    logic               scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic               start_det, stop_det;

    smb_state_e         state, state_nx;

    logic [BYTE_W-1:0]  sh_data;
    logic               sh_full;
    logic               sh_clr, sh_load, sh_rise, sh_tx;

    logic [BYTE_W-1:0]  ptr_q;
    logic               rw_q;
    logic               mack_q;

    smb_line_sync #(
        .LANES  (N_LANES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign scl_lvl  = lvl[LANE_SCL];
    assign sda_lvl  = lvl[LANE_SDA];
    assign scl_rise = rise[LANE_SCL];
    assign scl_fall = fall[LANE_SCL];

    smb_bus_cond u_cond (
        .scl_lvl  (scl_lvl),
        .sda_rise (rise[LANE_SDA]),
        .sda_fall (fall[LANE_SDA]),
        .start_o  (start_det),
        .stop_o   (stop_det)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR: begin
                    if (scl_fall && sh_full) begin
                        state_nx = (sh_data[BYTE_W-1 -: 7] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) state_nx = rw_q ? ST_TX : ST_PTR;
                ST_PTR:      if (scl_fall && sh_full) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall) state_nx = ST_DATA;
                ST_DATA:     if (scl_fall && sh_full) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_nx = ST_XTRA;
                ST_XTRA:     if (scl_fall && sh_full) state_nx = ST_XTRA_NAK;
                ST_XTRA_NAK: if (scl_fall) state_nx = ST_XTRA;
                ST_TX:       if (scl_fall && sh_full) state_nx = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_nx = mack_q ? ST_TX : ST_IGNORE;
                ST_IGNORE:   state_nx = ST_IGNORE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // ---------------- shifter control ----------------
    always_comb begin
        sh_tx   = (state == ST_TX);
        sh_rise = scl_rise && (state inside {ST_ADDR, ST_PTR, ST_DATA, ST_XTRA, ST_TX});
        sh_load = (state_nx == ST_TX) && (state != ST_TX);
        sh_clr  = (state_nx != state) || start_det;
    end

    smb_byte_shift #(
        .DW (BYTE_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sh_clr),
        .load     (sh_load),
        .load_val (reg_rdata),
        .tx_mode  (sh_tx),
        .rise     (sh_rise),
        .fall     (scl_fall),
        .bit_in   (sda_lvl),
        .data_o   (sh_data),
        .full_o   (sh_full)
    );

    // ---------------- registered outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (state == ST_ADDR && state_nx == ST_ADDR_ACK) begin
                rw_q <= sh_data[0];
            end
            if (state == ST_PTR && state_nx == ST_PTR_ACK) begin
                ptr_q <= sh_data;
            end
            if (state == ST_DATA && state_nx == ST_DATA_ACK) begin
                reg_we    <= 1'b1;
                reg_wdata <= sh_data;
            end
            if (state == ST_TX_ACK && scl_rise) begin
                mack_q <= ~sda_lvl;
            end
        end
    end

    assign reg_addr = ptr_q;

    // ---------------- open-drain drive ----------------
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_TX:                                sda_oe = ~sh_data[BYTE_W-1];
            default:                              sda_oe = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R10

    AST_WE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (state == ST_DATA_ACK && $past(state) == ST_DATA)); // R4

    AST_PTR_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |-> (state == ST_PTR_ACK)); // R6

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR)); // R7

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE)); // R11

    AST_TX_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && $past(state) == ST_TX && scl_lvl && $past(scl_lvl))
            |-> $stable(sda_oe)); // R5

endmodule

// File: tb/sim_smb_ptr_slave.sv
module sim_smb_ptr_slave;

    localparam int Q = 10; // quarter SCL period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;

    logic [7:0] bank [256];
    logic [7:0] exp_bank [256];
    int         exp_ptr = 0;
    logic [15:0] we_q [$];

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    smb_ptr_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_we) bank[reg_addr] <= reg_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the write strobe against the model's queue (R10, R4)
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (we_q.size() == 0) begin
                chk(1'b0, "R10 unexpected reg_we", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [15:0] e;
                e = we_q.pop_front();
                chk({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
            end
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; w(Q);
            scl_m = 1'b1; w(2 * Q);
            scl_m = 1'b0; w(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        send_bits(b, 8);
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        chk((sda_bus == 1'b0) == exp_ack, req, !sda_bus, exp_ack);
        w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit m_ack, input string req);
        logic [7:0] got;
        got = '0;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(Q);
            scl_m = 1'b1; w(Q);
            got[i] = sda_bus;
            w(Q);
            scl_m = 1'b0; w(Q);
        end
        chk(got == exp, req, got, exp);
        sda_m = m_ack ? 1'b0 : 1'b1; w(Q);
        scl_m = 1'b1; w(2 * Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic model_write(input logic [7:0] p, input logic [7:0] d);
        exp_ptr = p;
        exp_bank[p] = d;
        we_q.push_back({p, d});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            bank[i]     = 8'((i * 37 + 5) & 255);
            exp_bank[i] = 8'((i * 37 + 5) & 255);
        end
        w(5);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
        chk(reg_addr == 8'h00, "R1 pointer zero", reg_addr, 0);
        chk(reg_we == 1'b0, "R1 no strobe", reg_we, 0);
        rst_n = 1'b1;
        w(5);

        // R5 read at reset pointer, no pointer write first; R2 read address ack
        bus_start();
        send_byte(8'h5D, 1'b1, "R2 read address ack");
        recv_byte(exp_bank[exp_ptr], 1'b0, "R5 read at pointer 0");
        bus_stop();
        chk(reg_addr == 8'(exp_ptr), "R5 pointer unchanged", reg_addr, exp_ptr);

        // R3 send byte
        bus_start();
        send_byte(8'h5C, 1'b1, "R2 write address ack");
        send_byte(8'h40, 1'b1, "R3 pointer byte ack");
        bus_stop();
        exp_ptr = 8'h40;
        chk(reg_addr == 8'h40, "R3 pointer loaded", reg_addr, 8'h40);

        // R8 pointer persists across stop: bare read
        bus_start();
        send_byte(8'h5D, 1'b1, "R2 read address ack");
        recv_byte(exp_bank[exp_ptr], 1'b0, "R8 read after stop");
        bus_stop();

        // R4 write byte
        bus_start();
        send_byte(8'h5C, 1'b1, "R2 write address ack");
        send_byte(8'h11, 1'b1, "R3 pointer byte ack");
        model_write(8'h11, 8'hA5);
        send_byte(8'hA5, 1'b1, "R4 data byte ack");
        bus_stop();
        chk(reg_addr == 8'h11, "R4 pointer kept", reg_addr, 8'h11);
        bus_start();
        send_byte(8'h5D, 1'b1, "R2 read address ack");
        recv_byte(8'hA5, 1'b0, "R4 written value read back");
        bus_stop();

        // R6 surplus write bytes
        bus_start();
        send_byte(8'h5C, 1'b1, "R2 write address ack");
        send_byte(8'h22, 1'b1, "R3 pointer byte ack");
        model_write(8'h22, 8'h3C);
        send_byte(8'h3C, 1'b1, "R4 data byte ack");
        send_byte(8'h77, 1'b0, "R6 third byte nack");
        send_byte(8'h88, 1'b0, "R6 fourth byte nack");
        bus_stop();
        chk(reg_addr == 8'h22, "R6 pointer unchanged", reg_addr, 8'h22);
        bus_start();
        send_byte(8'h5D, 1'b1, "R2 read address ack");
        recv_byte(8'h3C, 1'b0, "R6 register unchanged by surplus");
        bus_stop();

        // R7 repeated start from write to read
        bus_start();
        send_byte(8'h5C, 1'b1, "R2 write address ack");
        send_byte(8'h40, 1'b1, "R3 pointer byte ack");
        exp_ptr = 8'h40;
        bus_start();
        send_byte(8'h5D, 1'b1, "R7 read address after restart");
        recv_byte(exp_bank[8'h40], 1'b0, "R7 read after restart");
        bus_stop();

        // R9 master ack repeats same register
        bus_start();
        send_byte(8'h5D, 1'b1, "R2 read address ack");
        recv_byte(exp_bank[8'h40], 1'b1, "R9 first byte");
        recv_byte(exp_bank[8'h40], 1'b0, "R9 repeat without increment");
        w(Q);
        chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        bus_stop();

        // R2 mismatched address
        bus_start();
        send_byte(8'h5A, 1'b0, "R2 foreign address nack");
        send_byte(8'h33, 1'b0, "R2 stays released");
        bus_stop();
        chk(reg_addr == 8'h40, "R2 pointer untouched", reg_addr, 8'h40);

        // R11 stop inside a byte
        bus_start();
        send_byte(8'h5C, 1'b1, "R2 write address ack");
        send_byte(8'h13, 1'b1, "R3 pointer byte ack");
        exp_ptr = 8'h13;
        send_bits(8'hFF, 4);
        scl_m = 1'b0;
        bus_stop();
        chk(reg_addr == 8'h13, "R11 pointer after abort", reg_addr, 8'h13);
        bus_start();
        send_byte(8'h5D, 1'b1, "R2 read address ack");
        recv_byte(exp_bank[8'h13], 1'b0, "R11 partial byte not written");
        bus_stop();

        w(20);
        chk(we_q.size() == 0, "R10 all expected strobes seen", we_q.size(), 0);
        chk(reg_we == 1'b0, "R10 strobe idle", reg_we, 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule